// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block lets a synchronous bus master inside the chip read and write an external asynchronous static RAM of 131,072 bytes. The master raises a one-cycle request with a write flag, a 17-bit address and a byte of write data. The controller then drives the memory's two chip enables (one active low, one active high), its active-low output and write strobes, and its address and data pins. When the access is finished it returns a one-cycle completion pulse, and for a read it returns the captured byte.

The memory has no clock. Every phase of an access is therefore timed by a cycle counter. Each count is derived at elaboration from a minimum or maximum memory timing given in nanoseconds and from the clock period, and is never less than one cycle. A write is always ended by the rising edge of the write strobe. The address and data stay in place for at least one cycle after that edge. The output strobe stays high for the whole write, so the memory never drives the pins while the controller does. After a read, the controller leaves a float interval before it drives the data pins again. Between accesses the memory is kept deselected.

The data pins are split into an output value, an output-enable and an input value, which a pad ring joins into one bidirectional bus.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, and whenever `busy` is low, the memory is deselected (`mem_ce_n`=1, `mem_ce`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `done`=0. A reset in the middle of an access returns to this state.
- R2: A request is accepted only in a cycle where `busy` is low. A request raised while `busy` is high has no effect: no access follows it and the memory contents stay unchanged.
- R3: A read holds both enables asserted, `mem_oe_n` low and `mem_we_n` high for RD = max(1, ceil(T_AA/CLK)) cycles. It samples `mem_dq_in` into `rdata` on the last of those cycles, so `rdata` equals the byte last written at that address.
- R4: After a read, `mem_oe_n` is high and the memory is deselected for HZ = max(ceil(T_HZ/CLK), ceil(T_RC/CLK) − RD, 1) cycles before any following access may drive `mem_dq_oe`.
- R5: During a write, `mem_oe_n` stays high throughout. `mem_we_n` is low for exactly WE = max(ceil(T_WP/CLK), ceil(T_AW/CLK) − 1, ceil(T_DW/CLK) − 1, 1) consecutive cycles, with both enables asserted and the data driven.
- R6: The write ends on the rising edge of `mem_we_n`. The enables, the address and the driven data remain for at least one cycle after it. `mem_addr` and `mem_dq_out` do not change while the memory is selected.
- R7: `done` is high for exactly one cycle per accepted access. It comes in the first cycle after the final phase, the cycle in which `busy` returns low. `busy` is high from the cycle after acceptance up to that cycle.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low or while the memory may still be driving the pins.
- R9: A write keeps the memory selected for at least ceil(T_WC/CLK) cycles. The hold phase after the write-enable rise, HOLD = max(1, ceil(T_WC/CLK) − 1 − WE), is padded to meet this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, sampled while idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Byte to write |
| rdata | output | DATA_W | Byte captured by the last read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |
| mem_ce_n | output | 1 | Memory enable, active low |
| mem_ce | output | 1 | Memory enable, active high |
| mem_oe_n | output | 1 | Memory output strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_out | output | DATA_W | Value driven onto the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | DATA_W | Value seen on the data pins |

## Verification
The following are checked on every clock cycle:
- the pin state in the deselected idle condition;
- the rule that the data pins are never driven while the output strobe is low;
- the exact width of the write-strobe pulse and the fact that the enables and data are still present when it rises;
- address and data stability while the memory is selected;
- the float gap ahead of any drive;
- the single-cycle completion pulse.

Some properties can only be shown by the bench's scenarios, using a timed behavioural memory that stores data and enforces the nanosecond limits:
- that a read returns the byte written earlier, including at the lowest and highest addresses;
- that a request made while busy leaves the memory unchanged;
- that the total write-cycle time and the access-time sampling point are honoured;
- that a reset in mid-access recovers cleanly.

// File: rtl/sram_port_ctrl.sv
`timescale 1ns/1ps
module sram_port_ctrl #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 70,
  parameter int T_RC_NS = 70,
  parameter int T_HZ_NS = 25,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_AW_NS = 60,
  parameter int T_DW_NS = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              busy,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int cyc(input int t_ns);
    int c;
    c = (t_ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = cyc(T_AA_NS);
  localparam int HZ_CYC  = mx(mx(cyc(T_HZ_NS), cyc(T_RC_NS) - RD_CYC), 1);
  localparam int WE_CYC  = mx(mx(cyc(T_WP_NS), cyc(T_AW_NS) - 1), mx(cyc(T_DW_NS) - 1, 1));
  localparam int WH_CYC  = mx(1, cyc(T_WC_NS) - 1 - WE_CYC);
  localparam int CNT_MAX = mx(mx(RD_CYC, HZ_CYC), mx(WE_CYC, WH_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RACC, S_RHZ, S_WSET, S_WPUL, S_WHLD} st_t;

  st_t              st, nxt;
  logic [CNT_W-1:0] cnt, cnt_ld;
  logic             last;

  assign last = (cnt == '0);
  assign busy = (st != S_IDLE);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (req) nxt = wr ? S_WSET : S_RACC;
      S_RACC: if (last) nxt = S_RHZ;
      S_RHZ:  if (last) nxt = S_IDLE;
      S_WSET: nxt = S_WPUL;
      S_WPUL: if (last) nxt = S_WHLD;
      S_WHLD: if (last) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      S_RACC:  cnt_ld = CNT_W'(RD_CYC - 1);
      S_RHZ:   cnt_ld = CNT_W'(HZ_CYC - 1);
      S_WPUL:  cnt_ld = CNT_W'(WE_CYC - 1);
      S_WHLD:  cnt_ld = CNT_W'(WH_CYC - 1);
      default: cnt_ld = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      mem_ce_n   <= 1'b1;
      mem_ce     <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      done       <= 1'b0;
      rdata      <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      st        <= nxt;
      cnt       <= (nxt != st) ? cnt_ld : (last ? cnt : cnt - 1'b1);
      mem_ce_n  <= !(nxt inside {S_RACC, S_WSET, S_WPUL, S_WHLD});
      mem_ce    <=  (nxt inside {S_RACC, S_WSET, S_WPUL, S_WHLD});
      mem_oe_n  <= (nxt != S_RACC);
      mem_we_n  <= (nxt != S_WPUL);
      mem_dq_oe <= (nxt inside {S_WSET, S_WPUL, S_WHLD});
      done      <= (st != S_IDLE) && (nxt == S_IDLE);
      if (st == S_IDLE && req) begin
        mem_addr   <= addr;
        mem_dq_out <= wdata;
      end
      if (st == S_RACC && last) rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_port_ctrl_chk.sv
`timescale 1ns/1ps
module sram_port_ctrl_chk #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 70,
  parameter int T_RC_NS = 70,
  parameter int T_HZ_NS = 25,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_AW_NS = 60,
  parameter int T_DW_NS = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  function automatic int cyc(input int t_ns);
    int c;
    c = (t_ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = cyc(T_AA_NS);
  localparam int HZ_CYC = mx(mx(cyc(T_HZ_NS), cyc(T_RC_NS) - RD_CYC), 1);
  localparam int WE_CYC = mx(mx(cyc(T_WP_NS), cyc(T_AW_NS) - 1), mx(cyc(T_DW_NS) - 1, 1));
  localparam int SAT    = HZ_CYC + 1;

  int we_run;
  int oe_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run <= 0;
      oe_gap <= SAT;
    end else begin
      we_run <= mem_we_n ? 0 : we_run + 1;
      oe_gap <= !mem_oe_n ? 0 : ((oe_gap < SAT) ? oe_gap + 1 : SAT);
    end
  end

  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R8
  AST_WE_WITH_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_ce && mem_dq_oe)); // R5
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run == WE_CYC)); // R5
  AST_WE_TERMINATES: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_ce && mem_dq_oe)); // R6
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && (!mem_dq_oe || $stable(mem_dq_out)))); // R6
  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_gap >= HZ_CYC)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS), .T_AA_NS(T_AA_NS),
  .T_RC_NS(T_RC_NS), .T_HZ_NS(T_HZ_NS), .T_WC_NS(T_WC_NS), .T_WP_NS(T_WP_NS),
  .T_AW_NS(T_AW_NS), .T_DW_NS(T_DW_NS)
) u_chk (.*);

// File: tb/sram_port_ctrl_test.sv
`timescale 1ns/1ps
module sram_port_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int T_AA = 70, T_RC = 70, T_HZ = 25, T_WC = 70, T_WP = 50, T_AW = 60, T_DW = 30;
  localparam int RD_X = 7, HZ_X = 3, WE_X = 5, WH_X = 1;
  localparam int WR_LAT = 1 + WE_X + WH_X + 1;
  localparam int RD_LAT = RD_X + HZ_X + 1;

  logic clk = 0, rst = 1, req = 0, wr = 0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic done, busy, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hA5;

  int n_run = 0, n_fail = 0;

  sram_port_ctrl uut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .busy(busy), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #(CLK_NS/2) clk = ~clk;

  // behavioural memory with timing checks
  logic [7:0] marr [int];
  logic [7:0] shadow [int];
  int en_cnt = 0, we_cnt = 0, rd_cnt = 0, hz_left = 0, dat_cnt = 0;
  int v_cont = 0, v_oe = 0, v_wtime = 0, v_term = 0, v_wc = 0, v_move = 0;
  int last_we = 0, last_wc = 0, writes = 0;
  logic we_prev = 1, sel_prev = 0, wrote = 0;
  logic [7:0]  dat_prev = '0;
  logic [16:0] addr_prev = '0;

  always @(negedge clk) begin
    logic sel, drive;
    if (rst) begin
      en_cnt = 0; we_cnt = 0; rd_cnt = 0; hz_left = 0; dat_cnt = 0;
      we_prev = 1; sel_prev = 0; wrote = 0;
      mem_dq_in <= 8'hA5;
    end else begin
      sel   = !mem_ce_n && mem_ce;
      drive = sel && !mem_oe_n && mem_we_n;
      if (mem_dq_oe && (drive || hz_left > 0)) v_cont++;
      hz_left = drive ? HZ_X : ((hz_left > 0) ? hz_left - 1 : 0);
      rd_cnt  = drive ? rd_cnt + 1 : 0;
      if (drive && rd_cnt * CLK_NS >= T_AA)
        mem_dq_in <= marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : 8'h00;
      else
        mem_dq_in <= 8'hA5;
      if (sel && sel_prev && mem_addr != addr_prev) v_move++;
      if (sel) en_cnt++;
      if (mem_dq_oe) dat_cnt = (dat_cnt > 0 && mem_dq_out == dat_prev) ? dat_cnt + 1 : 1;
      else dat_cnt = 0;
      if (!mem_we_n) begin
        if (!sel) v_term++;
        if (!mem_oe_n) v_oe++;
        we_cnt++;
      end else if (!we_prev) begin
        if (!sel || !mem_dq_oe) v_term++;
        if (we_cnt * CLK_NS < T_WP) v_wtime++;
        if ((en_cnt - 1) * CLK_NS < T_AW) v_wtime++;
        if ((dat_cnt - 1) * CLK_NS < T_DW) v_wtime++;
        marr[int'(mem_addr)] = mem_dq_out;
        last_we = we_cnt; we_cnt = 0; wrote = 1; writes++;
      end
      if (!sel && en_cnt > 0) begin
        if (wrote) begin
          last_wc = en_cnt;
          if (en_cnt * CLK_NS < T_WC) v_wc++;
        end
        en_cnt = 0; wrote = 0;
      end
      we_prev = mem_we_n; sel_prev = sel; addr_prev = mem_addr; dat_prev = mem_dq_out;
    end
  end

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string r);
    chk(mem_ce_n == 1 && mem_ce == 0, r, "enables deselected", {mem_ce_n, mem_ce}, 2);
    chk(mem_oe_n == 1 && mem_we_n == 1, r, "strobes inactive", {mem_oe_n, mem_we_n}, 3);
    chk(mem_dq_oe == 0, r, "bus released", mem_dq_oe, 0);
    chk(busy == 0 && done == 0, r, "busy/done low", {busy, done}, 0);
  endtask

  task automatic access(input bit w, input logic [16:0] a, input logic [7:0] d, output int lat);
    @(negedge clk); req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk); req = 0; lat = 1;
    chk(busy == 1, "R7", "busy after accept", busy, 1);
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk(busy == 0, "R7", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 0, "R7", "done one cycle", done, 0);
    if (w) shadow[int'(a)] = d;
  endtask

  task automatic t_reset();
    chk_idle("R1");
    chk(rdata == 0, "R1", "rdata reset", rdata, 0);
  endtask

  task automatic t_write(input logic [16:0] a, input logic [7:0] d);
    int lat, w0;
    w0 = writes;
    access(1, a, d, lat);
    chk(lat == WR_LAT, "R7", "write done latency", lat, WR_LAT);
    chk(writes == w0 + 1, "R5", "one write strobe", writes - w0, 1);
    chk(last_we == WE_X, "R5", "we_n low cycles", last_we, WE_X);
    chk(last_wc * CLK_NS >= T_WC, "R9", "write cycle cycles", last_wc, 7);
    chk_idle("R1");
  endtask

  task automatic t_read(input logic [16:0] a);
    int lat;
    logic [7:0] e;
    e = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    access(0, a, 8'h00, lat);
    chk(lat == RD_LAT, "R3", "read done latency", lat, RD_LAT);
    chk(rdata == e, "R3", "read data", rdata, e);
  endtask

  task automatic t_busy_ignore();
    int lat, dn;
    @(negedge clk); req = 1; wr = 1; addr = 17'h00123; wdata = 8'h3C;
    @(negedge clk); addr = 17'h00456; wdata = 8'hC3;
    @(negedge clk); @(negedge clk); req = 0;
    shadow[32'h123] = 8'h3C;
    lat = 3; dn = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (done) dn++; end
    chk(dn == 0, "R2", "extra done after ignored req", dn, 0);
    t_read(17'h00456);
    t_read(17'h00123);
  endtask

  task automatic t_mid_reset();
    @(negedge clk); req = 1; wr = 0; addr = 17'h00010;
    @(negedge clk); req = 0;
    @(negedge clk); @(negedge clk);
    rst = 1;
    @(negedge clk); @(negedge clk);
    chk_idle("R1");
    rst = 0;
    @(negedge clk);
    chk_idle("R1");
  endtask

  task automatic t_b2b();
    int lat;
    access(0, 17'h0AAAA, 8'h00, lat);
    @(negedge clk); req = 1; wr = 1; addr = 17'h0AAAB; wdata = 8'h5A;
    @(negedge clk); req = 0;
    while (!done) @(negedge clk);
    shadow[32'hAAAB] = 8'h5A;
    t_read(17'h0AAAB);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write(17'h00000, 8'h00);
    t_write(17'h1FFFF, 8'hFF);
    t_write(17'h0AAAA, 8'h96);
    t_read(17'h1FFFF);
    t_read(17'h00000);
    t_read(17'h0AAAA);
    t_read(17'h05555);
    t_write(17'h00000, 8'h81);
    t_read(17'h00000);
    t_busy_ignore();
    t_mid_reset();
    t_b2b();
    chk(v_cont == 0, "R8", "bus contention events", v_cont, 0);
    chk(v_cont == 0, "R4", "drive before float gap", v_cont, 0);
    chk(v_oe == 0, "R5", "oe_n low during write", v_oe, 0);
    chk(v_wtime == 0, "R5", "write width/setup violations", v_wtime, 0);
    chk(v_term == 0, "R6", "write not ended by we_n rise", v_term, 0);
    chk(v_move == 0, "R6", "address moved while selected", v_move, 0);
    chk(v_wc == 0, "R9", "write cycle too short", v_wc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule